// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Send Engine

This block takes 64-bit command writes from a core and turns each one into a 32-bit store into another core's register space. Each command names a destination core, carries a 32-bit payload and has a 4-bit lane mask. A set lane bit keeps the byte already held at the destination. A clear lane bit replaces that byte with the matching payload byte.

When any lane is kept, the engine first fetches the destination word over its master port, then writes the merged word back. When no lane is kept, the fetch is skipped and the payload is written as it stands. There are two command flavours, and they differ only in how the destination address is formed:
- The mailbox flavour picks one of eight mailbox words above a fixed base.
- The direct flavour carries the full 16-bit register address inside the command.

Every master access is tagged with the destination core's ID. Only one command is handled at a time. The command port stays busy until the final write has been accepted, and then a one-cycle response reports success or a decode error.

Top module: `mbox_send_engine`

## Requirements
- R1: After reset `cmd_ready_o` is 1 and `m_valid_o` and `rsp_valid_o` are 0. A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` then stays 0 until the cycle after the response pulse.
- R2: Only a write (`cmd_we_i`=1) of 8 bytes (`cmd_wide_i`=1) starts an operation, and only when `cmd_addr_i[11:0]` equals `MAIL_OFF` (default 0x008) or `ANY_OFF` (default 0x110). Address bits above bit 11 are ignored. Any other write, and any read, gets a response with error 0 and `rsp_rdata_o`=0, and causes no master access.
- R3: The destination core ID is `cmd_wdata_i[25:16]`. An ID at or above `NUM_CORES` gives a response with `rsp_err_o`=1 and no master access.
- R4: The keep mask is `cmd_wdata_i[30:27]`. When it is nonzero, exactly one read is issued at the destination address before the write.
- R5: When the keep mask is zero, no read is issued and the old word is taken as zero.
- R6: The written word is (old AND K) OR (`cmd_wdata_i[63:32]` AND NOT K). K has byte lane i set to 0xFF when keep bit i is 1.
- R7: For a mailbox command (`MAIL_OFF`), the destination address is `MBOX_BASE` + 0x20 + (`cmd_wdata_i` AND 0x1C).
- R8: For a direct command (`ANY_OFF`), the destination address is `cmd_wdata_i[15:0]`.
- R9: Every master access carries the destination ID on `m_core_o`. While `m_valid_o`=1 and `m_ready_i`=0, the request holds its address, direction and tag unchanged.
- R10: The cycle after the write is accepted (`m_valid_o`, `m_we_o` and `m_ready_i` all 1), `rsp_valid_o`=1 with `rsp_err_o`=0. `rsp_valid_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command accepted |
| cmd_we_i | input | 1 | 1 = write, 0 = read |
| cmd_wide_i | input | 1 | 1 = 8-byte access |
| cmd_addr_i | input | 16 | Command window address |
| cmd_wdata_i | input | 64 | Command word |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Decode error |
| rsp_rdata_o | output | 64 | Read data, always zero |
| m_valid_o | output | 1 | Master request valid |
| m_ready_i | input | 1 | Master request accepted |
| m_we_o | output | 1 | Master request is a write |
| m_addr_o | output | 16 | Destination register address |
| m_core_o | output | 10 | Destination core tag |
| m_wdata_o | output | 32 | Merged write word |
| m_rvalid_i | input | 1 | Read data valid |
| m_rdata_i | input | 32 | Read data |

## Verification
The main input patterns are the following:
- An all-zero keep mask separates the skipped-read path from the read-then-write path.
- A full mask checks that the old word is written back unchanged.
- Alternating lane masks expose any lane that is swapped or inverted.

Mailbox and direct commands are sent with the same payload low bits, which shows whether the right address derivation is used. Destination IDs just below and at the core limit, and the largest 10-bit ID, check the error boundary. Random commands are mixed with junk writes, narrow writes, reads and aliased upper address bits. A responder with random ready and read latency then confirms that the request holds and the tag follows the destination core.

// File: rtl/mbox_send_pkg.sv
package mbox_send_pkg;
  localparam int unsigned CMD_W    = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam int unsigned ID_LSB   = 16;
  localparam int unsigned ID_W     = 10;
  localparam int unsigned KEEP_LSB = 27;
  localparam int unsigned DATA_LSB = 32;
  localparam int unsigned TADDR_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_READ,
    ST_WRITE,
    ST_DONE
  } state_e;
endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
  import mbox_send_pkg::*;
#(
  parameter int unsigned               ADDR_W    = 16,
  parameter int unsigned               WIN_W     = 12,
  parameter int unsigned               NUM_CORES = 16,
  parameter logic [WIN_W-1:0]          MAIL_OFF  = 12'h008,
  parameter logic [WIN_W-1:0]          ANY_OFF   = 12'h110,
  parameter logic [TADDR_W-1:0]        MBOX_BASE = 16'h1000
) (
  input  logic               we_i,
  input  logic               wide_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CMD_W-1:0]   data_i,
  output logic               start_o,
  output logic               err_o,
  output logic [ID_W-1:0]    core_o,
  output logic [TADDR_W-1:0] taddr_o,
  output logic [LANES-1:0]   keep_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int unsigned LIM_W = ID_W + 1;
  localparam logic [LIM_W-1:0] CORE_LIMIT = LIM_W'(NUM_CORES);
  localparam logic [TADDR_W-1:0] MBOX_WORDS = MBOX_BASE + TADDR_W'(32'h20);

  logic hit_mail, hit_any, bad_id;
  logic unused_bits;

  assign hit_mail = we_i && wide_i && (addr_i[WIN_W-1:0] == MAIL_OFF);
  assign hit_any  = we_i && wide_i && (addr_i[WIN_W-1:0] == ANY_OFF);
  assign core_o   = data_i[ID_LSB +: ID_W];
  assign bad_id   = {1'b0, core_o} >= CORE_LIMIT;
  assign start_o  = (hit_mail || hit_any) && !bad_id;
  assign err_o    = (hit_mail || hit_any) && bad_id;
  assign keep_o   = data_i[KEEP_LSB +: LANES];
  assign word_o   = data_i[DATA_LSB +: WORD_W];

  // mailbox: one of eight words; direct: full address in the command
  always_comb begin
    if (hit_mail) taddr_o = MBOX_WORDS + {{(TADDR_W-5){1'b0}}, data_i[4:2], 2'b00};
    else          taddr_o = data_i[TADDR_W-1:0];
  end

  assign unused_bits = ^{addr_i[ADDR_W-1:WIN_W], data_i[31], data_i[26]};
endmodule

// File: rtl/mbox_byte_merge.sv
module mbox_byte_merge #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0]   keep_i,
  input  logic [LANES*8-1:0] old_i,
  input  logic [LANES*8-1:0] new_i,
  output logic [LANES*8-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*8 +: 8] = keep_i[l] ? old_i[l*8 +: 8] : new_i[l*8 +: 8];
  end
endmodule

// File: rtl/mbox_send_fsm.sv
module mbox_send_fsm
  import mbox_send_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic start_i,
  input  logic err_i,
  input  logic need_read_i,
  input  logic m_ready_i,
  input  logic m_rvalid_i,
  output logic cmd_ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic m_valid_o,
  output logic m_we_o,
  output logic rsp_valid_o,
  output logic rsp_err_o
);
  state_e state_q, state_d;
  logic   err_q;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept_o    = cmd_ready_o && cmd_valid_i;
  assign capture_o   = (state_q == ST_WAIT_READ) && m_rvalid_i;
  assign m_valid_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign m_we_o      = (state_q == ST_WRITE);
  assign rsp_valid_o = (state_q == ST_DONE);
  assign rsp_err_o   = rsp_valid_o && err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          if (start_i) state_d = need_read_i ? ST_READ : ST_WRITE;
          else         state_d = ST_DONE;
        end
      end
      ST_READ:      if (m_ready_i)  state_d = ST_WAIT_READ;
      ST_WAIT_READ: if (m_rvalid_i) state_d = ST_WRITE;
      ST_WRITE:     if (m_ready_i)  state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) err_q <= err_i;
    end
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !cmd_ready_o); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_we_o)); // R9
  AST_RSP_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && m_we_o && m_ready_i |=> rsp_valid_o && !rsp_err_o); // R10
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && cmd_ready_o); // R10
endmodule

// File: rtl/mbox_send_engine.sv
module mbox_send_engine
  import mbox_send_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        WIN_W     = 12,
  parameter int unsigned        NUM_CORES = 16,
  parameter logic [WIN_W-1:0]   MAIL_OFF  = 12'h008,
  parameter logic [WIN_W-1:0]   ANY_OFF   = 12'h110,
  parameter logic [TADDR_W-1:0] MBOX_BASE = 16'h1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_we_i,
  input  logic               cmd_wide_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [CMD_W-1:0]   cmd_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [CMD_W-1:0]   rsp_rdata_o,
  output logic               m_valid_o,
  input  logic               m_ready_i,
  output logic               m_we_o,
  output logic [TADDR_W-1:0] m_addr_o,
  output logic [ID_W-1:0]    m_core_o,
  output logic [WORD_W-1:0]  m_wdata_o,
  input  logic               m_rvalid_i,
  input  logic [WORD_W-1:0]  m_rdata_i
);
  logic               dec_start, dec_err, accept, capture;
  logic [ID_W-1:0]    dec_core, core_q;
  logic [TADDR_W-1:0] dec_taddr, taddr_q;
  logic [LANES-1:0]   dec_keep, keep_q;
  logic [WORD_W-1:0]  dec_word, word_q, old_q;

  mbox_cmd_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_CORES(NUM_CORES),
    .MAIL_OFF(MAIL_OFF), .ANY_OFF(ANY_OFF), .MBOX_BASE(MBOX_BASE)
  ) i_decode (
    .we_i(cmd_we_i), .wide_i(cmd_wide_i), .addr_i(cmd_addr_i), .data_i(cmd_wdata_i),
    .start_o(dec_start), .err_o(dec_err), .core_o(dec_core), .taddr_o(dec_taddr),
    .keep_o(dec_keep), .word_o(dec_word)
  );

  mbox_send_fsm i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
    .start_i(dec_start), .err_i(dec_err), .need_read_i(|dec_keep),
    .m_ready_i(m_ready_i), .m_rvalid_i(m_rvalid_i),
    .cmd_ready_o(cmd_ready_o), .accept_o(accept), .capture_o(capture),
    .m_valid_o(m_valid_o), .m_we_o(m_we_o),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o)
  );

  mbox_byte_merge #(.LANES(LANES)) i_merge (
    .keep_i(keep_q), .old_i(old_q), .new_i(word_q), .merged_o(m_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q  <= '0;
      taddr_q <= '0;
      keep_q  <= '0;
      word_q  <= '0;
      old_q   <= '0;
    end else begin
      if (accept) begin
        core_q  <= dec_core;
        taddr_q <= dec_taddr;
        keep_q  <= dec_keep;
        word_q  <= dec_word;
        old_q   <= '0;   // zero mask: merge against zero
      end
      if (capture) old_q <= m_rdata_i;
    end
  end

  assign m_addr_o    = taddr_q;
  assign m_core_o    = core_q;
  assign rsp_rdata_o = '0;

  AST_READ_NEEDS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_we_o |-> keep_q != '0); // R4
  AST_ZERO_KEEP_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && dec_start && dec_keep == '0 |=> m_valid_o && m_we_o); // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !dec_start |=> rsp_valid_o && !m_valid_o); // R3
  AST_TAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> $stable(m_addr_o) && $stable(m_core_o)); // R9
endmodule

// File: tb/test_mbox_send_engine.sv
module test_mbox_send_engine;
  localparam int unsigned NUM_CORES = 16;
  localparam logic [11:0] MAIL_OFF  = 12'h008;
  localparam logic [11:0] ANY_OFF   = 12'h110;
  localparam logic [15:0] MBOX_BASE = 16'h1000;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        rst_ni, cmd_valid_i, cmd_ready_o, cmd_we_i, cmd_wide_i;
  logic [15:0] cmd_addr_i;
  logic [63:0] cmd_wdata_i, rsp_rdata_o;
  logic        rsp_valid_o, rsp_err_o, m_valid_o, m_ready_i, m_we_o, m_rvalid_i;
  logic [15:0] m_addr_o;
  logic [9:0]  m_core_o;
  logic [31:0] m_wdata_o, m_rdata_i;

  mbox_send_engine #(.NUM_CORES(NUM_CORES), .MAIL_OFF(MAIL_OFF),
                     .ANY_OFF(ANY_OFF), .MBOX_BASE(MBOX_BASE)) i_mbox_send_engine (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_we_i, .cmd_wide_i,
    .cmd_addr_i, .cmd_wdata_i, .rsp_valid_o, .rsp_err_o, .rsp_rdata_o,
    .m_valid_o, .m_ready_i, .m_we_o, .m_addr_o, .m_core_o, .m_wdata_o,
    .m_rvalid_i, .m_rdata_i
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [logic [25:0]];
  int          rd_cnt, wr_cnt, rd_pend;
  logic [15:0] rd_addr, wr_addr;
  logic [9:0]  rd_core, wr_core;
  logic [31:0] wr_data;

  function automatic logic [31:0] mem_rd(logic [9:0] c, logic [15:0] a);
    if (mem.exists({c, a})) return mem[{c, a}];
    return {a, 6'h0, c} ^ 32'hA5C3_0F96;
  endfunction

  function automatic logic [63:0] mk(logic [31:0] hi, logic [3:0] keep,
                                     logic [9:0] id, logic [15:0] lo);
    return {hi, 1'b0, keep, 1'b0, id, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // responder: drives slave inputs at negedge, logs handshakes due at next posedge
  initial begin
    m_ready_i = 1'b0; m_rvalid_i = 1'b0; m_rdata_i = '0; rd_pend = 0;
    forever begin
      @(negedge clk_i);
      m_rvalid_i = 1'b0;
      if (rd_pend > 0) begin
        rd_pend--;
        if (rd_pend == 0) begin
          m_rvalid_i = 1'b1;
          m_rdata_i  = mem_rd(rd_core, rd_addr);
        end
      end
      m_ready_i = ($urandom % 4) != 0;
      if (rst_ni && m_valid_o && m_ready_i) begin
        if (m_we_o) begin
          wr_cnt++; wr_addr = m_addr_o; wr_core = m_core_o; wr_data = m_wdata_o;
          mem[{m_core_o, m_addr_o}] = m_wdata_o;
        end else begin
          rd_cnt++; rd_addr = m_addr_o; rd_core = m_core_o;
          rd_pend = 1 + int'($urandom % 3);
        end
      end
    end
  end

  task automatic do_cmd(input logic we, input logic wide, input logic [15:0] addr,
                        input logic [63:0] d);
    logic        is_mail, is_any, bad, send;
    logic [9:0]  id;
    logic [3:0]  keep;
    logic [15:0] ta;
    logic [31:0] old, km, exp_w;
    bit          got;
    is_mail = we && wide && addr[11:0] == MAIL_OFF;
    is_any  = we && wide && addr[11:0] == ANY_OFF;
    id      = d[25:16];
    keep    = d[30:27];
    bad     = int'(id) >= int'(NUM_CORES);
    send    = (is_mail || is_any) && !bad;
    ta      = is_mail ? MBOX_BASE + 16'h20 + {11'd0, d[4:2], 2'b00} : d[15:0];
    old     = (keep != 0) ? mem_rd(id, ta) : 32'h0;
    for (int l = 0; l < 4; l++) km[l*8 +: 8] = {8{keep[l]}};
    exp_w   = (old & km) | (d[63:32] & ~km);
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1 ready when idle", 64'(cmd_ready_o), 64'h1);
    cmd_valid_i = 1'b1; cmd_we_i = we; cmd_wide_i = wide; cmd_addr_i = addr; cmd_wdata_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(cmd_ready_o == 1'b0, "R1 busy after accept", 64'(cmd_ready_o), 64'h0);
    got = 0;
    for (int i = 0; i < 200; i++) begin
      if (rsp_valid_o) begin got = 1; break; end
      @(negedge clk_i);
    end
    chk(got, "R10 response seen", 64'(got), 64'h1);
    chk(rsp_err_o == ((is_mail || is_any) && bad), "R3 error flag",
        64'(rsp_err_o), 64'((is_mail || is_any) && bad));
    chk(rsp_rdata_o == 64'h0, "R2 read data zero", rsp_rdata_o, 64'h0);
    chk(rd_cnt == ((send && keep != 0) ? 1 : 0), "R4 R5 read count",
        64'(rd_cnt), 64'((send && keep != 0) ? 1 : 0));
    chk(wr_cnt == (send ? 1 : 0), "R2 R3 write count", 64'(wr_cnt), 64'(send ? 1 : 0));
    if (send && keep != 0) begin
      chk(rd_addr == ta, "R4 read address", 64'(rd_addr), 64'(ta));
      chk(rd_core == id, "R9 read tag", 64'(rd_core), 64'(id));
    end
    if (send) begin
      chk(wr_addr == ta, is_mail ? "R7 mailbox address" : "R8 direct address",
          64'(wr_addr), 64'(ta));
      chk(wr_core == id, "R9 write tag", 64'(wr_core), 64'(id));
      chk(wr_data == exp_w, "R6 merged word", 64'(wr_data), 64'(exp_w));
    end
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R10 single pulse", 64'(rsp_valid_o), 64'h0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0; cmd_valid_i = 1'b0; cmd_we_i = 1'b0; cmd_wide_i = 1'b0;
    cmd_addr_i = '0; cmd_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1 reset ready", 64'(cmd_ready_o), 64'h1);
    chk(m_valid_o == 1'b0, "R1 reset master idle", 64'(m_valid_o), 64'h0);
    chk(rsp_valid_o == 1'b0, "R1 reset no response", 64'(rsp_valid_o), 64'h0);

    do_cmd(1, 1, {4'h0, MAIL_OFF}, mk(32'h1122_3344, 4'h0, 10'd3, 16'h0014)); // R5 R7
    do_cmd(1, 1, {4'h0, MAIL_OFF}, mk(32'hAABB_CCDD, 4'h5, 10'd3, 16'h0014)); // R4 R6
    do_cmd(1, 1, {4'h0, ANY_OFF}, mk(32'hDEAD_BEEF, 4'hF, 10'(NUM_CORES-1), 16'h3ABC)); // R6 R8
    do_cmd(1, 1, {4'h0, ANY_OFF}, mk(32'h0, 4'hA, 10'(NUM_CORES), 16'h0100)); // R3
    do_cmd(1, 1, {4'h0, MAIL_OFF}, mk(32'h0, 4'h0, 10'h3FF, 16'h0000)); // R3
    do_cmd(1, 0, {4'h0, MAIL_OFF}, mk(32'h5555_5555, 4'h0, 10'd1, 16'h0)); // R2 narrow
    do_cmd(0, 1, {4'h0, ANY_OFF}, mk(32'h5555_5555, 4'h0, 10'd1, 16'h0)); // R2 read
    do_cmd(1, 1, 16'h000C, mk(32'h5555_5555, 4'h0, 10'd1, 16'h0)); // R2 other offset
    do_cmd(1, 1, {4'h5, MAIL_OFF}, mk(32'h0F0F_F0F0, 4'h6, 10'd2, 16'h001C)); // R2 alias R7

    for (int n = 0; n < 400; n++) begin
      logic [63:0] d;
      logic [15:0] a;
      logic [9:0]  id;
      logic [3:0]  k;
      int          sel;
      sel = int'($urandom % 20);
      id  = ($urandom % 5 == 0) ? 10'($urandom) : 10'($urandom % NUM_CORES);
      k   = ($urandom % 4 == 0) ? 4'h0 : 4'($urandom);
      d   = mk($urandom, k, id, 16'($urandom));
      d[31] = 1'($urandom); d[26] = 1'($urandom);
      a   = {4'($urandom), (sel < 9) ? MAIL_OFF : ANY_OFF};
      if (sel >= 18) a[11:0] = 12'($urandom);
      do_cmd(sel != 18, sel != 19, a, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule